// File: doc/BRIEF.md
# Radio Link Basic-Frame Multiplexer

This block forms the transmit side of a time-division-multiplexed radio-interface link layer. It merges a stream of baseband IQ words with control words into fixed basic frames of sixteen slots. Slot 0 of each basic frame carries a control word and slots 1 to 15 carry IQ samples. Every 256 basic frames make one super frame. The 256 control slots of a super frame together carry its control structure, so the frame index picks the control word for each control slot.

Each clock the block emits one slot as a parallel word for a downstream 8B/10B line coder. The output carries flags that mark the control slot, the start of a basic frame and the start of a super frame. The slot width is one, two or four bytes and follows the selected line rate. The clock is expected to scale with that rate, so a basic frame always lasts one period of 3.84 MHz. Control words come from an external 256-entry source. The block presents the index of the frame being built and reads the returned word in the same cycle. IQ words arrive over a valid/ready handshake. When no IQ word is available for a data slot, the block fills the slot with zeros and flags the frame.

Top module: `rl_frame_mux`

## Requirements
- R1: While `rst_n` is low, `iq_ready` and every `tx_*` output are 0. The first word after reset is slot 0 of frame 0, with `tx_super_start` high.
- R2: Output words repeat in groups of 16. The first word of each group has `tx_ctrl` and `tx_frame_start` high, and the other 15 words have both low. `tx_frame_start` is high exactly once every 16 cycles.
- R3: The frame index counts 0 to 255 and then wraps to 0. `tx_super_start` is high only on the slot-0 word of frame 0, which is once every 4096 words.
- R4: `ctrl_idx` equals the index of the frame whose slot 0 is being formed. The `ctrl_word` value presented in that cycle appears on `tx_word` one clock later, masked to the current slot width.
- R5: `iq_ready` is high in exactly the cycles that form slots 1 to 15. A word with `iq_valid` and `iq_ready` both high appears on `tx_word` one clock later. `iq_valid` during a slot-0 cycle has no effect: the control word is still sent and the IQ word is not consumed.
- R6: If `iq_valid` is low in a data-slot cycle, that slot's word is all zero. `tx_uflow` goes high with that word and stays high up to the last word of the frame. It is low on every slot-0 word.
- R7: Width codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The bytes above the active width read 0 on `tx_word`, and `tx_width` reports the code in force.
- R8: `rate_sel` is sampled only in the cycle that forms slot 15 of frame 255. The new width applies from the next super-frame start. Code 3 leaves the width unchanged. After reset the width is code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 2 | Requested slot width code |
| iq_valid | input | 1 | IQ word offered |
| iq_ready | output | 1 | IQ word taken this cycle |
| iq_data | input | 32 | IQ word, low bytes used |
| ctrl_idx | output | 8 | Frame index addressing the control source |
| ctrl_word | input | 32 | Control word for `ctrl_idx` |
| tx_word | output | 32 | Framed slot word to the line coder |
| tx_ctrl | output | 1 | Word is a control slot |
| tx_frame_start | output | 1 | First word of a basic frame |
| tx_super_start | output | 1 | First word of a super frame |
| tx_uflow | output | 1 | An IQ slot of this frame was zero-filled |
| tx_width | output | 2 | Width code of the word on `tx_word` |

## Verification
The hardest cases to reach from the ports are the width change and the wrap of the frame index. Both happen only at the super-frame boundary, 4096 cycles apart. To reach them, the stimulus runs uninterrupted across three boundaries. It holds several different `rate_sel` values during each super frame, so only the value present in the last cycle should take effect. One of the three boundaries is crossed with the reserved code.

// File: rtl/rl_mux_pkg.sv
package rl_mux_pkg;

    typedef enum logic [1:0] {
        WIDTH_1B  = 2'd0,
        WIDTH_2B  = 2'd1,
        WIDTH_4B  = 2'd2,
        WIDTH_RSV = 2'd3
    } width_e;

    // Number of live bytes for a width code; the reserved code never reaches here.
    function automatic logic [3:0] live_bytes(width_e w);
        case (w)
            WIDTH_1B: live_bytes = 4'd1;
            WIDTH_2B: live_bytes = 4'd2;
            default:  live_bytes = 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/rl_slot_timer.sv
module rl_slot_timer #(
    parameter int unsigned SLOTS  = 16,
    parameter int unsigned FRAMES = 256,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned IDX_W  = $clog2(FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rl_mux_pkg::width_e  rate_req,
    output logic [SLOT_W-1:0]   slot_o,
    output logic [IDX_W-1:0]    frame_o,
    output rl_mux_pkg::width_e  width_o,
    output logic                first_slot_o,
    output logic                super_first_o
);
    import rl_mux_pkg::*;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [IDX_W-1:0]  frame;
        width_e            width;
    } tstate_t;

    tstate_t tm_d, tm_q;
    logic    at_last_slot;
    logic    at_last_frame;

    always_comb begin
        tm_d          = tm_q;
        at_last_slot  = (tm_q.slot  == SLOT_W'(SLOTS - 1));
        at_last_frame = (tm_q.frame == IDX_W'(FRAMES - 1));
        if (at_last_slot) begin
            tm_d.slot = '0;
            if (at_last_frame) begin
                tm_d.frame = '0;
                // Width may only move on a super-frame boundary.
                if (rate_req != WIDTH_RSV) begin
                    tm_d.width = rate_req;
                end
            end else begin
                tm_d.frame = tm_q.frame + IDX_W'(1);
            end
        end else begin
            tm_d.slot = tm_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q.slot  <= '0;
            tm_q.frame <= '0;
            tm_q.width <= WIDTH_1B;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign slot_o        = tm_q.slot;
    assign frame_o       = tm_q.frame;
    assign width_o       = tm_q.width;
    assign first_slot_o  = (tm_q.slot == '0);
    assign super_first_o = (tm_q.slot == '0) && (tm_q.frame == '0);

endmodule

// File: rtl/rl_word_pick.sv
module rl_word_pick #(
    parameter int unsigned LANE_BYTES = 4,
    localparam int unsigned LANE_W = 8 * LANE_BYTES
) (
    input  logic               is_ctrl,
    input  logic [LANE_W-1:0]  ctrl_word,
    input  logic               iq_valid,
    input  logic [LANE_W-1:0]  iq_data,
    input  rl_mux_pkg::width_e width,
    output logic [LANE_W-1:0]  word_o,
    output logic               empty_o
);
    import rl_mux_pkg::*;

    logic [LANE_W-1:0] raw;
    logic [3:0]        nbytes;

    always_comb begin
        if (is_ctrl) begin
            raw = ctrl_word;
        end else if (iq_valid) begin
            raw = iq_data;
        end else begin
            raw = '0;
        end
        empty_o = !is_ctrl && !iq_valid;
        nbytes  = live_bytes(width);
    end

    for (genvar i = 0; i < LANE_BYTES; i++) begin : g_lane
        assign word_o[8*i +: 8] = (4'(i) < nbytes) ? raw[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/rl_frame_mux.sv
module rl_frame_mux #(
    parameter int unsigned LANE_BYTES = 4,
    parameter int unsigned SLOTS      = 16,
    parameter int unsigned FRAMES     = 256,
    localparam int unsigned LANE_W = 8 * LANE_BYTES,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned IDX_W  = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              iq_valid,
    output logic              iq_ready,
    input  logic [LANE_W-1:0] iq_data,
    output logic [IDX_W-1:0]  ctrl_idx,
    input  logic [LANE_W-1:0] ctrl_word,
    output logic [LANE_W-1:0] tx_word,
    output logic              tx_ctrl,
    output logic              tx_frame_start,
    output logic              tx_super_start,
    output logic              tx_uflow,
    output logic [1:0]        tx_width
);
    import rl_mux_pkg::*;

    typedef struct packed {
        logic [LANE_W-1:0] word;
        logic              ctrl;
        logic              fs;
        logic              sfs;
        logic              uflow;
        width_e            width;
    } out_t;

    out_t ob_d, ob_q;

    logic [SLOT_W-1:0] cur_slot;
    logic [IDX_W-1:0]  cur_frame;
    width_e            cur_width;
    logic              first_slot;
    logic              super_first;
    logic [LANE_W-1:0] picked;
    logic              slot_empty;

    rl_slot_timer #(
        .SLOTS  (SLOTS),
        .FRAMES (FRAMES)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .rate_req      (width_e'(rate_sel)),
        .slot_o        (cur_slot),
        .frame_o       (cur_frame),
        .width_o       (cur_width),
        .first_slot_o  (first_slot),
        .super_first_o (super_first)
    );

    rl_word_pick #(
        .LANE_BYTES (LANE_BYTES)
    ) u_pick (
        .is_ctrl   (first_slot),
        .ctrl_word (ctrl_word),
        .iq_valid  (iq_valid),
        .iq_data   (iq_data),
        .width     (cur_width),
        .word_o    (picked),
        .empty_o   (slot_empty)
    );

    always_comb begin
        ob_d       = ob_q;
        ob_d.word  = picked;
        ob_d.ctrl  = first_slot;
        ob_d.fs    = first_slot;
        ob_d.sfs   = super_first;
        ob_d.width = cur_width;
        // Flag lives from the first starved slot to the end of its frame.
        ob_d.uflow = first_slot ? 1'b0 : (ob_q.uflow | slot_empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_q.word  <= '0;
            ob_q.ctrl  <= 1'b0;
            ob_q.fs    <= 1'b0;
            ob_q.sfs   <= 1'b0;
            ob_q.uflow <= 1'b0;
            ob_q.width <= WIDTH_1B;
        end else begin
            ob_q <= ob_d;
        end
    end

    // The timer holds slot 0 in reset, so ready is already low there.
    assign iq_ready       = !first_slot;
    assign ctrl_idx       = cur_frame;
    assign tx_word        = ob_q.word;
    assign tx_ctrl        = ob_q.ctrl;
    assign tx_frame_start = ob_q.fs;
    assign tx_super_start = ob_q.sfs;
    assign tx_uflow       = ob_q.uflow;
    assign tx_width       = ob_q.width;

endmodule

// File: rtl/rl_frame_mux_chk.sv
module rl_frame_mux_chk #(
    parameter int unsigned LANE_BYTES = 4,
    parameter int unsigned SLOTS      = 16,
    localparam int unsigned LANE_W = 8 * LANE_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iq_valid,
    input logic              iq_ready,
    input logic [LANE_W-1:0] tx_word,
    input logic              tx_ctrl,
    input logic              tx_frame_start,
    input logic              tx_super_start,
    input logic              tx_uflow,
    input logic [1:0]        tx_width
);
    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tx_frame_start) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    // R5: a cycle that accepts IQ never produces a control word.
    assert_ready_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iq_ready |=> !tx_ctrl);

    // R2: a cycle that refuses IQ produces the frame's control word.
    assert_ctrl_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !iq_ready |=> (tx_ctrl && tx_frame_start));

    // R2: frame starts are spaced by exactly SLOTS words.
    assert_frame_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && tx_frame_start) |-> (gap_q == 16'(SLOTS - 1)));

    // R3: super-frame start falls on a frame start.
    assert_super_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_super_start |-> tx_frame_start);

    // R6: a starved data slot yields a zero word with the flag up.
    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_ready && !iq_valid) |=> (tx_word == '0 && tx_uflow));

    // R6: the flag drops only as a new frame starts.
    assert_uflow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_uflow) |-> tx_frame_start);

    // R8: width moves only with a super-frame start.
    assert_width_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_super_start |-> $stable(tx_width));

    // R8: the reserved code is never in force.
    assert_width_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_width != 2'd3);

    if (LANE_BYTES > 1) begin : g_mask
        // R7: one-byte slots keep upper bytes at zero.
        assert_lane_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_width == 2'd0) |-> (tx_word[LANE_W-1:8] == '0));
    end

endmodule

bind rl_frame_mux rl_frame_mux_chk #(
    .LANE_BYTES (LANE_BYTES),
    .SLOTS      (SLOTS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .iq_valid       (iq_valid),
    .iq_ready       (iq_ready),
    .tx_word        (tx_word),
    .tx_ctrl        (tx_ctrl),
    .tx_frame_start (tx_frame_start),
    .tx_super_start (tx_super_start),
    .tx_uflow       (tx_uflow),
    .tx_width       (tx_width)
);

// File: tb/tb_rl_frame_mux.sv
module tb_rl_frame_mux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        iq_valid = 1'b0;
    logic        iq_ready;
    logic [31:0] iq_data = '0;
    logic [7:0]  ctrl_idx;
    logic [31:0] ctrl_word;
    logic [31:0] tx_word;
    logic        tx_ctrl;
    logic        tx_frame_start;
    logic        tx_super_start;
    logic        tx_uflow;
    logic [1:0]  tx_width;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cyc = 0;
    logic [1:0]  cur_w = 2'd0;
    logic        uf_prev = 1'b0;

    always #5 clk = ~clk;

    // Bench-side control source: distinct word per frame index.
    assign ctrl_word = {8'hC5, ctrl_idx, ~ctrl_idx, ctrl_idx ^ 8'h3C};

    rl_frame_mux dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rate_sel       (rate_sel),
        .iq_valid       (iq_valid),
        .iq_ready       (iq_ready),
        .iq_data        (iq_data),
        .ctrl_idx       (ctrl_idx),
        .ctrl_word      (ctrl_word),
        .tx_word        (tx_word),
        .tx_ctrl        (tx_ctrl),
        .tx_frame_start (tx_frame_start),
        .tx_super_start (tx_super_start),
        .tx_uflow       (tx_uflow),
        .tx_width       (tx_width)
    );

    function automatic logic [31:0] wmask(logic [1:0] w);
        case (w)
            2'd0:    wmask = 32'h0000_00FF;
            2'd1:    wmask = 32'h0000_FFFF;
            default: wmask = 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic ck(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at pos %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        ck(iq_ready == 1'b0, "R1", "iq_ready in reset", 32'(iq_ready), 0);
        ck(tx_word == '0, "R1", "tx_word in reset", tx_word, 0);
        ck({tx_ctrl, tx_frame_start, tx_super_start, tx_uflow} == 4'b0, "R1", "flags in reset",
           32'({tx_ctrl, tx_frame_start, tx_super_start, tx_uflow}), 0);
        ck(tx_width == 2'd0, "R1", "tx_width in reset", 32'(tx_width), 0);
        rst_n = 1'b1;
        cyc = 0;
        cur_w = 2'd0;
        uf_prev = 1'b0;
    endtask

    // Drive and check every slot until position end_pos; gap bit set = no IQ word.
    task automatic run_until(input int unsigned end_pos, input logic [15:0] gap,
                             input logic [1:0] rate);
        while (cyc < end_pos) begin
            int unsigned slot;
            int unsigned frame;
            logic [31:0] data;
            logic [31:0] exp_word;
            logic        exp_uf;
            logic [1:0]  next_w;
            slot  = cyc % 16;
            frame = (cyc / 16) % 256;
            data  = (cyc + 1) * 32'h9E37_79B9;
            rate_sel = rate;
            iq_valid = !gap[slot];
            iq_data  = data;
            #1;
            ck(iq_ready == (slot != 0), "R5", "iq_ready", 32'(iq_ready), 32'(slot != 0));
            ck(ctrl_idx == 8'(frame), "R4", "ctrl_idx", 32'(ctrl_idx), frame);
            if (slot == 0) begin
                exp_word = {8'hC5, 8'(frame), ~8'(frame), 8'(frame) ^ 8'h3C} & wmask(cur_w);
                exp_uf   = 1'b0;
            end else begin
                exp_word = iq_valid ? (data & wmask(cur_w)) : 32'h0;
                exp_uf   = uf_prev | !iq_valid;
            end
            next_w = cur_w;
            if (slot == 15 && frame == 255 && rate != 2'd3) next_w = rate;
            @(posedge clk);
            @(negedge clk);
            ck(tx_word == exp_word, (slot == 0) ? "R4" : "R5/R6/R7", "tx_word", tx_word, exp_word);
            ck(tx_ctrl == (slot == 0), "R2", "tx_ctrl", 32'(tx_ctrl), 32'(slot == 0));
            ck(tx_frame_start == (slot == 0), "R2", "tx_frame_start",
               32'(tx_frame_start), 32'(slot == 0));
            ck(tx_super_start == (slot == 0 && frame == 0), "R3", "tx_super_start",
               32'(tx_super_start), 32'(slot == 0 && frame == 0));
            ck(tx_uflow == exp_uf, "R6", "tx_uflow", 32'(tx_uflow), 32'(exp_uf));
            ck(tx_width == cur_w, "R8", "tx_width", 32'(tx_width), 32'(cur_w));
            cyc++;
            uf_prev = exp_uf;
            cur_w = next_w;
        end
    endtask

    task automatic t_first_word();
        // R1: first word after reset is the super-frame start.
        run_until(1, 16'h0000, 2'd0);
        ck(tx_super_start == 1'b1, "R1", "first word super start", 32'(tx_super_start), 1);
    endtask

    task automatic t_full_frames();
        // R2 R4 R5 R7: steady IQ, valid held high in slot 0 too.
        run_until(48, 16'h0000, 2'd2);
        ck(tx_width == 2'd0, "R7", "one-byte width before boundary", 32'(tx_width), 0);
    endtask

    task automatic t_underflow();
        // R6: starved slots 1, 2, 5 and 15 in one frame, then clean frames.
        run_until(64, 16'h8026, 2'd2);
        run_until(96, 16'h0000, 2'd2);
        ck(tx_uflow == 1'b0, "R6", "flag clear after clean frame", 32'(tx_uflow), 0);
    endtask

    task automatic t_rate_change();
        // R8: only the value present at the last slot of frame 255 counts.
        run_until(2000, 16'h0000, 2'd2);
        run_until(4096 + 48, 16'h0000, 2'd1);
        ck(tx_width == 2'd1, "R8", "two-byte width after boundary", 32'(tx_width), 1);
        // R3 R8: reserved code leaves width alone across the next boundary.
        run_until(6000, 16'h0010, 2'd0);
        run_until(8192 + 48, 16'h0000, 2'd3);
        ck(tx_width == 2'd1, "R8", "reserved code ignored", 32'(tx_width), 1);
        // R7: four-byte slots after the third boundary.
        run_until(12288 + 48, 16'h0000, 2'd2);
        ck(tx_width == 2'd2, "R7", "four-byte width", 32'(tx_width), 2);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_word();
        t_full_frames();
        t_underflow();
        t_rate_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule